// File: doc/BRIEF.md
# Vblank Evasion Update Gate

This block decides when a batch of double-buffered display register writes may begin, so that the whole batch falls inside a single frame. A requester raises `req`. The gate compares the current scanline against a guard window that ends just before vertical blanking starts. If the scanline lies inside that window, the grant is held back until the scanline leaves the window or a timeout runs out, whichever comes first.

The guard window length comes from a fixed 100 µs budget. The gate converts this budget to scanlines from the pixel clock (in kHz) and the horizontal total. In interlaced mode the vblank start line is halved, rounding up.

At grant time the gate records the vblank counter. When the requester pulses `done`, the gate compares that recorded count with the current count. A change means the batch straddled a vblank, and the gate raises an update-failure flag. The window bounds and the scanline seen at grant time stay on debug outputs until the next request is accepted.

Top module: `vblank_gate`

## Requirements
- R1: The guard length in scanlines is ceil(100 × pix_khz / (1000 × htotal)), saturated to 2^LINE_W − 1. When htotal is 0 the guard length is 1.
- R2: When `interlaced` is 1, the effective vblank start is ceil(vbl_start / 2). Otherwise it is vbl_start.
- R3: On an accepted request, `dbg_lo` takes effective start − guard and `dbg_hi` takes effective start − 1. Both are signed and are held until the next accepted request.
- R4: If either bound is zero or negative, the request is granted in the cycle after acceptance whatever the scanline. The start count is then recorded as 0, so no update failure can follow.
- R5: A request accepted while the scanline is below `dbg_lo` or above `dbg_hi` is granted in the cycle after acceptance. `grant` is always a single-cycle pulse.
- R6: A request accepted with the scanline inside [lo, hi] (both ends inclusive) gets no grant while the scanline stays inside. The grant is raised in the cycle after an edge at which the scanline is outside.
- R7: If the scanline stays inside for CLK_PER_MS cycles after acceptance, the gate grants anyway and sets `timeout_flag`. `timeout_flag` stays set until the next accepted request.
- R8: A `done` pulse after the grant returns the gate to idle. It sets `update_fail` when the recorded start count is non-zero and differs from `vbl_count` at `done`. `update_fail` is cleared at the next accepted request.
- R9: `busy` is high from acceptance until `done` is taken. `req` is ignored while `busy` is high.
- R10: `dbg_scan_start` holds the scanline sampled at the edge that produced the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scanline | input | LINE_W | Current scanline |
| vbl_start | input | LINE_W | Line on which vblank starts |
| htotal | input | LINE_W | Horizontal total in pixels |
| pix_khz | input | CLK_W | Pixel clock in kHz |
| interlaced | input | 1 | Interlaced timing |
| vbl_count | input | CNT_W | Running vblank counter |
| req | input | 1 | Request to start an update batch |
| done | input | 1 | One-cycle pulse: batch finished |
| grant | output | 1 | One-cycle pulse: batch may start |
| busy | output | 1 | Request in progress |
| timeout_flag | output | 1 | Grant was forced by the timeout |
| update_fail | output | 1 | Vblank counter changed during the batch |
| dbg_lo | output | LINE_W+1 | Signed lower window bound |
| dbg_hi | output | LINE_W+1 | Signed upper window bound |
| dbg_scan_start | output | LINE_W | Scanline at grant |

## Verification
The assertions assume that `done` arrives only after the grant and that `scanline` changes only between clock edges. The bench drives every input at falling edges and pulses `done` only once a grant has been seen, so both assumptions hold.

The bench sweeps horizontal totals (zero included), pixel clocks (zero included), both interlace settings and a spread of vblank start lines. For each combination it checks the latched bounds, the skip path and the failure flag against arithmetic done in the bench. It also walks the scanline across both window edges and holds it inside the window long enough to force the timeout.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } gate_state_e;
endpackage

// File: rtl/vbg_window.sv
module vbg_window #(
    parameter int LINE_W = 12,
    parameter int CLK_W  = 20
) (
    input  logic [LINE_W-1:0]      vbl_start,
    input  logic [LINE_W-1:0]      htotal,
    input  logic [CLK_W-1:0]       pix_khz,
    input  logic                   interlaced,
    output logic signed [LINE_W:0] lo,
    output logic signed [LINE_W:0] hi,
    output logic                   skip
);
    localparam int MW = CLK_W + LINE_W + 12;
    localparam logic [MW-1:0] GMAX = MW'((64'd1 << LINE_W) - 64'd1);

    logic [LINE_W:0]   vs_half;
    logic [LINE_W-1:0] vs_eff;
    logic [MW-1:0]     num, den, guard_full;
    logic [LINE_W-1:0] guard;

    always_comb begin
        vs_half    = ({1'b0, vbl_start} + (LINE_W+1)'(1)) >> 1;
        vs_eff     = interlaced ? vs_half[LINE_W-1:0] : vbl_start;
        num        = MW'(pix_khz) * MW'(100);
        den        = MW'(htotal) * MW'(1000);
        guard_full = (htotal == '0) ? MW'(1) : (num + den - MW'(1)) / den;
        guard      = (guard_full > GMAX) ? GMAX[LINE_W-1:0] : guard_full[LINE_W-1:0];
        lo         = $signed({1'b0, vs_eff}) - $signed({1'b0, guard});
        hi         = $signed({1'b0, vs_eff}) - $signed((LINE_W+1)'(1));
        skip       = lo[LINE_W] || (lo == '0) || hi[LINE_W] || (hi == '0);
    end
endmodule

// File: rtl/vbg_timer.sv
module vbg_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(LIMIT - 1);
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R7: the count never leaves its loaded range
    assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/vblank_gate.sv
module vblank_gate
    import vbg_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int CLK_W      = 20,
    parameter int CNT_W      = 32,
    parameter int CLK_PER_MS = 100000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LINE_W-1:0]      scanline,
    input  logic [LINE_W-1:0]      vbl_start,
    input  logic [LINE_W-1:0]      htotal,
    input  logic [CLK_W-1:0]       pix_khz,
    input  logic                   interlaced,
    input  logic [CNT_W-1:0]       vbl_count,
    input  logic                   req,
    input  logic                   done,
    output logic                   grant,
    output logic                   busy,
    output logic                   timeout_flag,
    output logic                   update_fail,
    output logic signed [LINE_W:0] dbg_lo,
    output logic signed [LINE_W:0] dbg_hi,
    output logic [LINE_W-1:0]      dbg_scan_start
);
    typedef struct packed {
        gate_state_e              state;
        logic                     grant;
        logic                     tmo;
        logic                     fail;
        logic                     skip;
        logic signed [LINE_W:0]   lo;
        logic signed [LINE_W:0]   hi;
        logic [LINE_W-1:0]        scan_start;
        logic [CNT_W-1:0]         start_cnt;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    logic signed [LINE_W:0] lo_w, hi_w;
    logic                   skip_w;
    logic                   tmr_load, tmr_run, tmr_expired;
    logic signed [LINE_W:0] scan_s;
    logic                   out_now, out_held;

    vbg_window #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u_window (
        .vbl_start (vbl_start),
        .htotal    (htotal),
        .pix_khz   (pix_khz),
        .interlaced(interlaced),
        .lo        (lo_w),
        .hi        (hi_w),
        .skip      (skip_w)
    );

    vbg_timer #(.LIMIT(CLK_PER_MS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    always_comb begin
        scan_s   = $signed({1'b0, scanline});
        out_now  = (scan_s < lo_w) || (scan_s > hi_w);
        out_held = (scan_s < r_q.lo) || (scan_s > r_q.hi);
        r_d       = r_q;
        r_d.grant = 1'b0;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    r_d.lo   = lo_w;
                    r_d.hi   = hi_w;
                    r_d.skip = skip_w;
                    r_d.tmo  = 1'b0;
                    r_d.fail = 1'b0;
                    if (skip_w || out_now) begin
                        r_d.state      = ST_ACTIVE;
                        r_d.grant      = 1'b1;
                        r_d.scan_start = scanline;
                        r_d.start_cnt  = skip_w ? '0 : vbl_count;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                if (out_held || tmr_expired) begin
                    r_d.state      = ST_ACTIVE;
                    r_d.grant      = 1'b1;
                    r_d.tmo        = !out_held;
                    r_d.scan_start = scanline;
                    r_d.start_cnt  = vbl_count;
                end
            end
            ST_ACTIVE: begin
                if (done) begin
                    r_d.state = ST_IDLE;
                    r_d.fail  = (r_q.start_cnt != '0) && (r_q.start_cnt != vbl_count);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant          = r_q.grant;
    assign busy           = (r_q.state != ST_IDLE);
    assign timeout_flag   = r_q.tmo;
    assign update_fail    = r_q.fail;
    assign dbg_lo         = r_q.lo;
    assign dbg_hi         = r_q.hi;
    assign dbg_scan_start = r_q.scan_start;

    // R5: grant lasts one cycle
    assert_grant_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    // R6: an unforced, unskipped grant saw the scanline outside the window
    assert_grant_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !r_q.tmo && !r_q.skip) |->
        (($signed({1'b0, $past(scanline)}) < r_q.lo) || ($signed({1'b0, $past(scanline)}) > r_q.hi)));

    // R7: the timeout flag rises only together with a grant
    assert_timeout_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> grant);

    // R8: the failure flag rises only when done is taken in the active state
    assert_fail_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(update_fail) |-> $past(done && r_q.state == ST_ACTIVE));

    // R9: a grant always leaves the gate busy
    assert_busy_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy);
endmodule

// File: tb/vblank_gate_tb.sv
module vblank_gate_tb;
    localparam int LW = 12;
    localparam int CW = 20;
    localparam int NW = 32;
    localparam int CPM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] scanline = '0, vbl_start = '0, htotal = '0;
    logic [CW-1:0] pix_khz = '0;
    logic interlaced = 1'b0;
    logic [NW-1:0] vbl_count = '0;
    logic req = 1'b0, done = 1'b0;
    logic grant, busy, timeout_flag, update_fail;
    logic signed [LW:0] dbg_lo, dbg_hi;
    logic [LW-1:0] dbg_scan_start;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vblank_gate #(.LINE_W(LW), .CLK_W(CW), .CNT_W(NW), .CLK_PER_MS(CPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .scanline(scanline), .vbl_start(vbl_start),
        .htotal(htotal), .pix_khz(pix_khz), .interlaced(interlaced),
        .vbl_count(vbl_count), .req(req), .done(done), .grant(grant),
        .busy(busy), .timeout_flag(timeout_flag), .update_fail(update_fail),
        .dbg_lo(dbg_lo), .dbg_hi(dbg_hi), .dbg_scan_start(dbg_scan_start)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns the number of falling edges from acceptance until grant is seen
    task automatic do_req(output int n);
        @(negedge clk) req = 1'b1;
        @(posedge clk);
        @(negedge clk) req = 1'b0;
        n = 1;
        while (!grant && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_done(input logic [NW-1:0] cnt);
        @(negedge clk) begin vbl_count = cnt; done = 1'b1; end
        @(posedge clk);
        @(negedge clk) done = 1'b0;
    endtask

    function automatic longint exp_guard(input longint ht, input longint pk);
        longint g;
        if (ht == 0) return 1;
        g = (100 * pk + 1000 * ht - 1) / (1000 * ht);
        if (g > 4095) g = 4095;
        return g;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int hts[3] = '{0, 800, 2200};
        int pks[3] = '{0, 25175, 148500};
        int vss[5] = '{1, 2, 3, 480, 1081};
        repeat (3) @(negedge clk);
        check(grant == 0 && busy == 0 && timeout_flag == 0 && update_fail == 0,
              "reset R9", {grant, busy, timeout_flag, update_fail}, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R8: sweep of window arithmetic, scanline 0
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int il = 0; il < 2; il++)
                    for (int c = 0; c < 5; c++) begin
                        longint vse, g, lo, hi;
                        bit sk;
                        vse = il ? (vss[c] + 1) / 2 : vss[c];
                        g   = exp_guard(hts[a], pks[b]);
                        lo  = vse - g;
                        hi  = vse - 1;
                        sk  = (lo <= 0) || (hi <= 0);
                        htotal = LW'(hts[a]); pix_khz = CW'(pks[b]);
                        interlaced = il[0]; vbl_start = LW'(vss[c]);
                        scanline = '0; vbl_count = 7;
                        do_req(n);
                        check(n == 1, "R5 immediate grant", n, 1);
                        check(dbg_lo == lo, "R1 R2 R3 lower bound", dbg_lo, lo);
                        check(dbg_hi == hi, "R2 R3 upper bound", dbg_hi, hi);
                        do_done(9);
                        check(update_fail == !sk, "R4 R8 skip clears start count", update_fail, !sk);
                        check(busy == 0, "R9 idle after done", busy, 0);
                    end

        // window 476..479 (guard 4)
        htotal = 800; pix_khz = 25175; interlaced = 0; vbl_start = 480;

        // R6 R10 R5 R9: hold inside, then release
        scanline = 477; vbl_count = 3;
        @(negedge clk) req = 1'b1;
        @(posedge clk);
        @(negedge clk) req = 1'b0;
        check(busy == 1, "R9 busy after accept", busy, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(grant == 0, "R6 held inside window", grant, 0);
        end
        scanline = 480;
        @(negedge clk);
        check(grant == 1, "R6 grant after leaving window", grant, 1);
        check(dbg_scan_start == 480, "R10 scan at grant", dbg_scan_start, 480);
        check(timeout_flag == 0, "R7 no timeout", timeout_flag, 0);
        req = 1'b1;
        @(negedge clk);
        check(grant == 0, "R5 single-cycle grant", grant, 0);
        req = 1'b0;
        do_done(3);
        check(update_fail == 0, "R8 equal counts no failure", update_fail, 0);
        @(negedge clk);
        check(busy == 0, "R9 req ignored while busy", busy, 0);

        // R7: forced grant after timeout
        scanline = 478; vbl_count = 5;
        do_req(n);
        check(n == CPM + 1, "R7 timeout latency", n, CPM + 1);
        check(timeout_flag == 1, "R7 timeout flag", timeout_flag, 1);
        check(dbg_scan_start == 478, "R10 scan at forced grant", dbg_scan_start, 478);
        do_done(6);
        check(update_fail == 1, "R8 counter changed", update_fail, 1);
        check(timeout_flag == 1, "R7 flag held", timeout_flag, 1);

        // boundaries: 475 and 480 outside, 476 and 479 inside
        scanline = 475;
        do_req(n);
        check(n == 1, "R5 just below lower bound", n, 1);
        check(timeout_flag == 0 && update_fail == 0, "R7 R8 flags cleared on accept",
              {timeout_flag, update_fail}, 0);
        do_done(5);
        scanline = 476;
        do_req(n);
        check(n == CPM + 1, "R6 lower bound inclusive", n, CPM + 1);
        do_done(5);
        scanline = 479;
        do_req(n);
        check(n == CPM + 1, "R6 upper bound inclusive", n, CPM + 1);
        do_done(5);
        scanline = 480;
        do_req(n);
        check(n == 1, "R5 at vblank start", n, 1);
        do_done(0);
        check(update_fail == 1, "R8 end count zero differs", update_fail, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule